// File: doc/BRIEF.md
# Strided Data Prefetch Engine

This block watches the block addresses of data cache misses and looks for streams that step through a page by a fixed stride. Each stream is followed by one tracker in a table of eight. A tracker starts when two misses in a row land close together in one page. It is confirmed once a third access repeats the same nonzero step. From then on it issues prefetch block addresses along that stride, up to twelve lines beyond the latest demand access, and never outside the page.

Requests leave through a valid/ready pair. One request is granted per cycle among the trackers that have work, in rotating order. Addresses are block addresses: 64-byte blocks and 4 KB pages, so a page holds 64 blocks and the page number is `miss_blk[ADDR_W-1:6]`. The block does not filter prefetches against cache contents.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset no prefetch request is valid, and no request appears before at least three misses have been seen.
- R2: A new tracker is created only when a miss that matches no tracker directly follows a miss in the same page at a distance of fewer than 4 blocks (under 256 bytes). Pairs that are 4 or more blocks apart, or that fall in different pages, create nothing.
- R3: Misses at b, b+N, b+2N confirm a stream, where N is nonzero. The first prefetch is b+3N, followed by b+4N and so on.
- R4: A confirmed stream has at most 12 outstanding lines beyond its latest demand access. Each further demand that keeps the stride allows exactly one more line.
- R5: Prefetches stay inside the stream's page. The stream stops at the last in-page block on its stride.
- R6: Negative strides are followed in the same way as positive ones.
- R7: A step of zero never confirms a stream.
- R8: A miss whose step differs from the stored stride replaces the stride and stops prefetching. Prefetching resumes, starting one stride past that miss, only after the new step repeats.
- R9: Each page has at most one tracker, and up to 8 pages are tracked. With all trackers in use, an allocation replaces the tracker least recently allocated or hit by a miss.
- R10: When several trackers have work, one request is issued per cycle, and the grant rotates among them.
- R11: While `pf_vld` is high and `pf_rdy` is low, `pf_vld` and `pf_blk` hold, and no line is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | 1 | A data cache miss is reported this cycle |
| miss_blk | input | ADDR_W | Block address of the miss |
| pf_vld | output | 1 | Prefetch request valid |
| pf_blk | output | ADDR_W | Block address to prefetch |
| pf_rdy | input | 1 | Consumer accepts the request |

## Verification
Directed sequences are used to pin exact request lists, and each one targets a single distinction:
- a positive stride, to check where prefetching starts and where the twelve-line cap stops it;
- one extra demand, to check that it releases exactly one more line;
- a stride near the page edge, to check page confinement;
- a negative stride;
- a repeated block, to check that a zero step never confirms;
- a changed step, to check that confirmation is dropped and rebuilt;
- far and cross-page pairs, to check that no tracker is allocated;
- nine pages with one of them refreshed, to check that replacement picks the least recently updated tracker and not a fixed slot;
- two streams confirmed together, to check that the grant rotates rather than following fixed priority.

Random rounds then interleave four streams with random strides, start points and lengths under random backpressure. Each round checks that every stream's requests stay on its stride, only move forward, and end exactly at the cap or at the page edge.

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int ADDR_W     = 26,
  parameter int BLK_BYTES  = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int NEAR_BYTES = 256,
  parameter int NTRK       = 8,
  parameter int AHEAD      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_vld,
  input  logic [ADDR_W-1:0] miss_blk,
  output logic              pf_vld,
  output logic [ADDR_W-1:0] pf_blk,
  input  logic              pf_rdy
);
  localparam int OFF_W    = $clog2(PAGE_BYTES / BLK_BYTES);
  localparam int PG_W     = ADDR_W - OFF_W;
  localparam int SW       = OFF_W + 1;
  localparam int NEAR_BLK = NEAR_BYTES / BLK_BYTES;
  localparam int IDX_W    = $clog2(NTRK);
  localparam int CNT_W    = $clog2(AHEAD + 1);

  logic [NTRK-1:0]            t_val, t_conf, hit, pend;
  logic [PG_W-1:0]            t_pg   [NTRK];
  logic [OFF_W-1:0]           t_last [NTRK];
  logic [ADDR_W-1:0]          t_next [NTRK];
  logic signed [SW-1:0]       t_str  [NTRK];
  logic [IDX_W-1:0]           t_age  [NTRK];
  logic [NTRK-1:0][CNT_W-1:0] t_ahd;

  logic              p_val;
  logic [ADDR_W-1:0] p_blk;
  logic [IDX_W-1:0]  rr, hit_idx, vic, tidx, gnt;
  logic              hit_any, near, alloc, touch, gnt_any, load;
  logic signed [SW-1:0] dlt, nd;

  function automatic logic [ADDR_W-1:0] sx(input logic signed [SW-1:0] s);
    return {{(ADDR_W-SW){s[SW-1]}}, s};
  endfunction

  wire [PG_W-1:0]  miss_pg  = miss_blk[ADDR_W-1:OFF_W];
  wire [OFF_W-1:0] miss_off = miss_blk[OFF_W-1:0];

  always_comb begin
    hit_idx = '0;
    vic     = '0;
    for (int i = 0; i < NTRK; i++) begin
      hit[i] = t_val[i] && t_pg[i] == miss_pg;
      if (hit[i]) hit_idx = IDX_W'(i);
      if (t_age[i] == IDX_W'(NTRK-1)) vic = IDX_W'(i);
    end
    for (int i = NTRK-1; i >= 0; i--)
      if (!t_val[i]) vic = IDX_W'(i);
  end

  assign hit_any = |hit;
  assign dlt   = $signed({1'b0, miss_off}) - $signed({1'b0, t_last[hit_idx]});
  assign nd    = $signed({1'b0, miss_off}) - $signed({1'b0, p_blk[OFF_W-1:0]});
  assign near  = p_val && p_blk[ADDR_W-1:OFF_W] == miss_pg && nd > -NEAR_BLK && nd < NEAR_BLK;
  assign alloc = miss_vld && !hit_any && near;
  assign touch = miss_vld && (hit_any || alloc);
  assign tidx  = hit_any ? hit_idx : vic;

  always_comb begin
    for (int i = 0; i < NTRK; i++)
      pend[i] = t_val[i] && t_conf[i] && t_ahd[i] < AHEAD &&
                t_next[i][ADDR_W-1:OFF_W] == t_pg[i] && !(touch && tidx == IDX_W'(i));
    gnt_any = 1'b0;
    gnt     = '0;
    for (int k = NTRK-1; k >= 0; k--) begin
      int j;
      j = (int'(rr) + k) % NTRK;
      if (pend[j]) begin
        gnt_any = 1'b1;
        gnt     = IDX_W'(j);
      end
    end
  end

  assign load = (!pf_vld || pf_rdy) && gnt_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_val  <= '0;
      t_conf <= '0;
      t_ahd  <= '0;
      for (int i = 0; i < NTRK; i++) t_age[i] <= IDX_W'(i);
      p_val  <= 1'b0;
      pf_vld <= 1'b0;
      rr     <= '0;
    end else begin
      if (miss_vld) begin
        p_val <= 1'b1;
        p_blk <= miss_blk;
      end
      if (!pf_vld || pf_rdy) pf_vld <= gnt_any;
      if (load) begin
        pf_blk      <= t_next[gnt];
        t_next[gnt] <= t_next[gnt] + sx(t_str[gnt]);
        t_ahd[gnt]  <= t_ahd[gnt] + 1'b1;
        rr          <= IDX_W'((int'(gnt) + 1) % NTRK);
      end
      if (touch)
        for (int j = 0; j < NTRK; j++)
          if (IDX_W'(j) == tidx) t_age[j] <= '0;
          else if (t_age[j] < t_age[tidx]) t_age[j] <= t_age[j] + 1'b1;
      if (alloc) begin
        t_val[vic]  <= 1'b1;
        t_conf[vic] <= 1'b0;
        t_pg[vic]   <= miss_pg;
        t_last[vic] <= miss_off;
        t_str[vic]  <= nd;
        t_ahd[vic]  <= '0;
      end else if (miss_vld && hit_any) begin
        t_last[hit_idx] <= miss_off;
        if (dlt == t_str[hit_idx] && dlt != 0) begin
          t_conf[hit_idx] <= 1'b1;
          if (!t_conf[hit_idx] || t_ahd[hit_idx] == 0) begin
            t_next[hit_idx] <= miss_blk + sx(dlt);
            t_ahd[hit_idx]  <= '0;
          end else begin
            t_ahd[hit_idx] <= t_ahd[hit_idx] - 1'b1;
          end
        end else begin
          t_str[hit_idx]  <= dlt;
          t_conf[hit_idx] <= 1'b0;
          t_ahd[hit_idx]  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/stride_prefetcher_chk.sv
module stride_prefetcher_chk #(
  parameter int ADDR_W = 26,
  parameter int NTRK   = 8,
  parameter int AHEAD  = 12,
  parameter int CNT_W  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       miss_vld,
  input logic                       pf_vld,
  input logic                       pf_rdy,
  input logic [ADDR_W-1:0]          pf_blk,
  input logic [NTRK-1:0]            hit,
  input logic [NTRK-1:0][CNT_W-1:0] ahd
);
  logic [1:0] nmiss;
  always_ff @(posedge clk)
    if (!rst_n) nmiss <= '0;
    else if (miss_vld && nmiss != 2'd3) nmiss <= nmiss + 2'd1;

  p_idle_after_reset_r1: assert property (@(posedge clk) !rst_n |=> !pf_vld);

  p_three_misses_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pf_vld |-> nmiss == 2'd3);

  p_hold_on_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pf_vld && !pf_rdy |=> pf_vld && $stable(pf_blk));

  p_one_tracker_per_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  for (genvar i = 0; i < NTRK; i++) begin : g_cap
    p_ahead_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ahd[i] <= CNT_W'(AHEAD));
  end
endmodule

bind stride_prefetcher stride_prefetcher_chk #(
  .ADDR_W(ADDR_W), .NTRK(NTRK), .AHEAD(AHEAD), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .pf_vld(pf_vld),
  .pf_rdy(pf_rdy), .pf_blk(pf_blk), .hit(hit), .ahd(t_ahd)
);

// File: tb/sim_stride_prefetcher.sv
module sim_stride_prefetcher;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 26;

  logic clk = 1'b0, rst_n = 1'b0, miss_vld = 1'b0, pf_rdy = 1'b1;
  logic [ADDR_W-1:0] miss_blk = '0;
  logic pf_vld;
  logic [ADDR_W-1:0] pf_blk;
  int total = 0, fails = 0, rdy_mode = 1, acc_n = 0;
  logic [ADDR_W-1:0] acc [0:1023];

  always #(PERIOD/2) clk = ~clk;

  stride_prefetcher #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .miss_blk(miss_blk),
    .pf_vld(pf_vld), .pf_blk(pf_blk), .pf_rdy(pf_rdy));

  always @(posedge clk) begin
    #1;
    if (rdy_mode == 0) pf_rdy = 1'b0;
    else if (rdy_mode == 1) pf_rdy = 1'b1;
    else pf_rdy = ($urandom % 4) != 0;
  end

  always @(negedge clk)
    if (pf_vld && pf_rdy) begin
      if (acc_n < 1024) acc[acc_n] = pf_blk;
      acc_n++;
    end

  function automatic int mk(int pg, int off);
    return pg * 64 + off;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic miss(int pg, int off);
    @(posedge clk); #1;
    miss_vld = 1'b1;
    miss_blk = ADDR_W'(mk(pg, off));
    @(posedge clk); #1;
    miss_vld = 1'b0;
  endtask

  task automatic expect_seq(int pg, int off0, int s, int k0, int cnt, string req);
    int bad, first_a, first_e;
    wait_cyc(40);
    chk(acc_n == cnt, req, "prefetch count", acc_n, cnt);
    bad = 0; first_a = 0; first_e = 0;
    for (int i = 0; i < acc_n && i < cnt; i++)
      if (int'(acc[i]) != mk(pg, off0 + (k0 + i) * s)) begin
        if (bad == 0) begin first_a = int'(acc[i]); first_e = mk(pg, off0 + (k0 + i) * s); end
        bad++;
      end
    chk(bad == 0, req, "prefetch address", first_a, first_e);
    acc_n = 0;
  endtask

  task automatic rand_round(int pg0);
    int st[4], s[4], m[4], dn[4], lastk[4];
    int bad, left;
    for (int j = 0; j < 4; j++) begin
      s[j]  = int'($urandom % 3) + 1;
      if ($urandom % 2) s[j] = -s[j];
      st[j] = (s[j] > 0) ? int'($urandom % 21) : 43 + int'($urandom % 21);
      m[j]  = 3 + int'($urandom % 6);
      lastk[j] = 2;
    end
    acc_n = 0;
    rdy_mode = 2;
    for (int j = 0; j < 4; j++) begin
      miss(pg0 + j, st[j]);
      miss(pg0 + j, st[j] + s[j]);
      dn[j] = 1;
    end
    left = 0;
    for (int j = 0; j < 4; j++) left += m[j] - 1;
    while (left > 0) begin
      int j;
      j = int'($urandom % 4);
      if (dn[j] < m[j]) begin
        dn[j]++;
        left--;
        miss(pg0 + j, st[j] + dn[j] * s[j]);
        wait_cyc(int'($urandom % 4));
      end
    end
    wait_cyc(300);
    rdy_mode = 1;
    wait_cyc(40);
    bad = 0;
    for (int i = 0; i < acc_n; i++) begin
      int p, off, d, k;
      p = int'(acc[i]) / 64 - pg0;
      off = int'(acc[i]) % 64;
      if (p < 0 || p > 3) bad++;
      else begin
        d = off - st[p];
        k = d / s[p];
        if (d % s[p] != 0 || k < 3 || k <= lastk[p]) bad++;
        else lastk[p] = k;
      end
    end
    chk(bad == 0, "R5", "random: requests off stride, out of page or out of order", bad, 0);
    for (int j = 0; j < 4; j++) begin
      int kp, ef;
      kp = (s[j] > 0) ? (63 - st[j]) / s[j] : st[j] / (-s[j]);
      ef = (m[j] + 12 < kp) ? m[j] + 12 : kp;
      if (ef < 3) ef = 2;
      chk(lastk[j] == ef, "R4", "random: last stride index reached", lastk[j], ef);
    end
    acc_n = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual 0 expected 1 (run ended)");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    wait_cyc(3); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(pf_vld == 1'b0, "R1", "pf_vld after reset", int'(pf_vld), 0);

    // R3 R4 R8: start at b+3N, cap at 12, one more per demand, restart on new step
    miss(77, 0); miss(77, 2); miss(77, 4);
    expect_seq(77, 0, 2, 3, 12, "R3");
    miss(77, 6);
    expect_seq(77, 28, 2, 1, 1, "R4");
    miss(77, 7);
    expect_seq(77, 0, 1, 0, 0, "R8");
    miss(77, 8);
    expect_seq(77, 8, 1, 1, 12, "R8");

    // R5 page edge, R6 negative stride, R7 zero stride
    miss(76, 50); miss(76, 53); miss(76, 56);
    expect_seq(76, 50, 3, 3, 2, "R5");
    miss(75, 20); miss(75, 19); miss(75, 18);
    expect_seq(75, 20, -1, 3, 12, "R6");
    miss(74, 8); miss(74, 8); miss(74, 8); miss(74, 8);
    expect_seq(74, 8, 0, 0, 0, "R7");

    // R2: far pairs, distance exactly 4, cross-page neighbours
    miss(70, 0); miss(70, 5); miss(70, 10);
    miss(73, 0); miss(73, 4); miss(73, 8);
    miss(71, 63); miss(72, 0); miss(71, 62); miss(72, 1);
    expect_seq(70, 0, 0, 0, 0, "R2");

    // R11: stall holds the request, nothing lost
    rdy_mode = 0;
    miss(30, 0); miss(30, 1); miss(30, 2);
    wait_cyc(3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(pf_vld == 1'b1 && int'(pf_blk) == mk(30, 3), "R11", "stalled request", int'(pf_blk), mk(30, 3));
    end
    rdy_mode = 1;
    expect_seq(30, 0, 1, 3, 12, "R11");

    // R9: least recently updated tracker is replaced
    for (int p = 61; p <= 68; p++) begin miss(p, 0); miss(p, 1); end
    miss(61, 1);
    miss(69, 0); miss(69, 1);
    miss(62, 2);
    expect_seq(62, 0, 0, 0, 0, "R9");
    miss(61, 2); miss(61, 3);
    expect_seq(61, 0, 1, 4, 12, "R9");

    // R10: two streams share the request port in turn
    miss(20, 0); miss(20, 1); miss(21, 0); miss(21, 1); miss(20, 2); miss(21, 2);
    wait_cyc(40);
    begin
      int pairs, na, nb;
      pairs = 0; na = 0; nb = 0;
      for (int i = 0; i < acc_n; i++) begin
        if (int'(acc[i]) / 64 == 20) na++;
        if (int'(acc[i]) / 64 == 21) nb++;
        if (i > 0 && int'(acc[i]) / 64 == int'(acc[i-1]) / 64 && na < 12 && nb < 12) pairs++;
      end
      chk(na == 12 && nb == 12, "R10", "requests per stream (first stream)", na, 12);
      chk(pairs <= 2, "R10", "back-to-back grants to one stream", pairs, 2);
    end
    acc_n = 0;

    rand_round(40);
    rand_round(50);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule